// File: doc/BRIEF.md
# Two-Bank GPIO Controller with Transmit/Receive Automatic Output Words

The block controls two banks of general-purpose pins, one for the receive side and one for the transmit side, through a 16-bit register bus. Each pin has four settings, one bit in each of four word-wide registers: a software data value, a direction bit, a source-select bit and a debug bit. An output pin can take its value from one of four sources: the software data register, an automatic word chosen by the radio's live transmit/receive state, or one of two internal debug buses.

The automatic unit holds eight 16-bit words, one per side for each of four radio states: idle, receiving only, transmitting only and both. The state comes straight from the `tx_active` and `rx_active` inputs, so the chosen word follows them without a clock cycle of delay. Software reads the data register of a bank to see that bank's pad inputs after a two-flop synchroniser. The block drives an output-enable and an output value for each pad. The tristate pad cells themselves sit outside the block.

Top module: `gpio_atr_ctrl`

## Requirements
- R1: After reset every register is zero, so `pad_oe_rx`, `pad_oe_tx`, `pad_out_rx` and `pad_out_tx` are all 0.
- R2: Byte addresses 0x00, 0x02, 0x04 and 0x06 hold the receive bank's data, direction, select and debug registers. Addresses 0x08, 0x0A, 0x0C and 0x0E hold the same four registers for the transmit bank. A read of a direction, select or debug register returns the last value written to it.
- R3: A read of a bank's data register returns that bank's pad input after two clock edges of synchronisation. It never returns the value software wrote there.
- R4: A pin's output enable equals its direction bit. It changes at the clock edge that writes the direction register.
- R5: A pin whose debug bit is 0 and select bit is 0 drives its bank's software data bit.
- R6: A pin whose debug bit is 0 and select bit is 1 drives the bit of the automatic word for its side and the current state. The word for state S and side D (receive 0, transmit 1) sits at byte address 0x10 + 4*S + 2*D, where S = 2*tx_active + rx_active.
- R7: A change on `tx_active` or `rx_active` changes the automatic-sourced outputs in the same cycle, with no clock edge in between.
- R8: A pin whose debug bit is 1 drives debug bus 0 when its select bit is 0 and debug bus 1 when its select bit is 1.
- R9: A pin whose direction bit is 0 drives 0 on its output-value port, whatever its source.
- R10: Address bit 0 is ignored, so an access at an odd address acts on the word at the even address below it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| tx_active | input | 1 | Radio is transmitting |
| rx_active | input | 1 | Radio is receiving |
| dbg0_rx | input | 16 | Debug bus 0, receive bank |
| dbg1_rx | input | 16 | Debug bus 1, receive bank |
| dbg0_tx | input | 16 | Debug bus 0, transmit bank |
| dbg1_tx | input | 16 | Debug bus 1, transmit bank |
| pad_in_rx | input | 16 | Pad inputs, receive bank |
| pad_in_tx | input | 16 | Pad inputs, transmit bank |
| pad_out_rx | output | 16 | Pad output values, receive bank |
| pad_out_tx | output | 16 | Pad output values, transmit bank |
| pad_oe_rx | output | 16 | Pad output enables, receive bank |
| pad_oe_tx | output | 16 | Pad output enables, transmit bank |

## Verification
The output mux is driven in four ways: all pins on software data, all pins on automatic words while the bench steps through the four radio states, mixed per-pin masks across both debug buses, and a partial direction mask. The automatic pass stores eight distinct words whose values encode their state and side. A wrong state decode or a swapped side therefore shows up as a wrong value, not a lucky match. Reads of the data register are sampled one and two edges after a pad change, which separates a correct two-flop path from a shorter path or from a readback of the stored word. An odd-address write finds address decodes that use bit 0.

// File: rtl/gpio_atr_pkg.sv
package gpio_atr_pkg;

    localparam int BUS_W    = 16;
    localparam int ADDR_W   = 5;
    localparam int N_BANKS  = 2;
    localparam int N_STATES = 4;

    // bank index: 0 = receive side, 1 = transmit side
    localparam int BANK_RX = 0;
    localparam int BANK_TX = 1;

    typedef logic [BUS_W-1:0] word_t;

    typedef enum logic [1:0] {
        FLD_DATA = 2'd0,
        FLD_DIR  = 2'd1,
        FLD_SEL  = 2'd2,
        FLD_DBG  = 2'd3
    } field_e;

    // state index = {tx_active, rx_active}
    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_RX   = 2'b01,
        ST_TX   = 2'b10,
        ST_FULL = 2'b11
    } radio_state_e;

    typedef struct packed {
        word_t data;
        word_t dir;
        word_t sel;
        word_t dbg;
    } bank_cfg_t;

    typedef word_t [N_STATES-1:0][N_BANKS-1:0] atr_table_t;

    function automatic logic pin_source(input logic dbg, input logic sel,
                                        input logic sw, input logic atr,
                                        input logic d0, input logic d1);
        if (dbg) return sel ? d1 : d0;
        return sel ? atr : sw;
    endfunction

endpackage

// File: rtl/gpio_atr_regfile.sv
module gpio_atr_regfile
    import gpio_atr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            bus_wr,
    input  logic [ADDR_W-1:0]               bus_addr,
    input  word_t                           bus_wdata,
    output word_t                           bus_rdata,
    input  word_t [N_BANKS-1:0]             pad_in,
    output bank_cfg_t [N_BANKS-1:0]         cfg,
    output atr_table_t                      atr
);

    logic   is_atr;
    logic   bank_idx;
    field_e field;
    logic [1:0] st_idx;
    logic   side_idx;

    assign is_atr   = bus_addr[4];
    assign bank_idx = bus_addr[3];
    assign field    = field_e'(bus_addr[2:1]);
    assign st_idx   = bus_addr[3:2];
    assign side_idx = bus_addr[1];

    word_t [N_BANKS-1:0] pad_sync;

    for (genvar b = 0; b < N_BANKS; b++) begin : g_sync
        word_t [SYNC_STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            chain[0] <= pad_in[b];
            for (int i = 1; i < SYNC_STAGES; i++) chain[i] <= chain[i-1];
        end
        assign pad_sync[b] = chain[SYNC_STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
            atr <= '0;
        end else if (bus_wr) begin
            if (is_atr) begin
                atr[st_idx][side_idx] <= bus_wdata;
            end else begin
                case (field)
                    FLD_DATA: cfg[bank_idx].data <= bus_wdata;
                    FLD_DIR:  cfg[bank_idx].dir  <= bus_wdata;
                    FLD_SEL:  cfg[bank_idx].sel  <= bus_wdata;
                    FLD_DBG:  cfg[bank_idx].dbg  <= bus_wdata;
                    default:  ;
                endcase
            end
        end
    end

    always_comb begin
        if (is_atr) begin
            bus_rdata = atr[st_idx][side_idx];
        end else begin
            case (field)
                FLD_DATA: bus_rdata = pad_sync[bank_idx];
                FLD_DIR:  bus_rdata = cfg[bank_idx].dir;
                FLD_SEL:  bus_rdata = cfg[bank_idx].sel;
                FLD_DBG:  bus_rdata = cfg[bank_idx].dbg;
                default:  bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_atr_select.sv
module gpio_atr_select
    import gpio_atr_pkg::*;
(
    input  atr_table_t           atr,
    input  logic                 tx_active,
    input  logic                 rx_active,
    output word_t [N_BANKS-1:0]  atr_word
);

    radio_state_e state;
    assign state = radio_state_e'({tx_active, rx_active});

    for (genvar b = 0; b < N_BANKS; b++) begin : g_side
        assign atr_word[b] = atr[state][b];
    end

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
    import gpio_atr_pkg::*;
(
    input  bank_cfg_t cfg,
    input  word_t     atr_word,
    input  word_t     dbg0,
    input  word_t     dbg1,
    output word_t     pad_out,
    output word_t     pad_oe
);

    for (genvar p = 0; p < BUS_W; p++) begin : g_pin
        logic src;
        assign src        = pin_source(cfg.dbg[p], cfg.sel[p], cfg.data[p],
                                       atr_word[p], dbg0[p], dbg1[p]);
        assign pad_oe[p]  = cfg.dir[p];
        assign pad_out[p] = cfg.dir[p] & src;
    end

endmodule

// File: rtl/gpio_atr_ctrl.sv
module gpio_atr_ctrl
    import gpio_atr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              tx_active,
    input  logic              rx_active,
    input  logic [BUS_W-1:0]  dbg0_rx,
    input  logic [BUS_W-1:0]  dbg1_rx,
    input  logic [BUS_W-1:0]  dbg0_tx,
    input  logic [BUS_W-1:0]  dbg1_tx,
    input  logic [BUS_W-1:0]  pad_in_rx,
    input  logic [BUS_W-1:0]  pad_in_tx,
    output logic [BUS_W-1:0]  pad_out_rx,
    output logic [BUS_W-1:0]  pad_out_tx,
    output logic [BUS_W-1:0]  pad_oe_rx,
    output logic [BUS_W-1:0]  pad_oe_tx
);

    bank_cfg_t [N_BANKS-1:0] cfg;
    atr_table_t              atr;
    word_t [N_BANKS-1:0]     atr_word;
    word_t [N_BANKS-1:0]     pad_in_v;
    word_t [N_BANKS-1:0]     dbg0_v;
    word_t [N_BANKS-1:0]     dbg1_v;
    word_t [N_BANKS-1:0]     out_v;
    word_t [N_BANKS-1:0]     oe_v;

    assign pad_in_v[BANK_RX] = pad_in_rx;
    assign pad_in_v[BANK_TX] = pad_in_tx;
    assign dbg0_v[BANK_RX]   = dbg0_rx;
    assign dbg0_v[BANK_TX]   = dbg0_tx;
    assign dbg1_v[BANK_RX]   = dbg1_rx;
    assign dbg1_v[BANK_TX]   = dbg1_tx;

    gpio_atr_regfile #(.SYNC_STAGES(SYNC_STAGES)) i_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in_v),
        .cfg       (cfg),
        .atr       (atr)
    );

    gpio_atr_select i_sel (
        .atr       (atr),
        .tx_active (tx_active),
        .rx_active (rx_active),
        .atr_word  (atr_word)
    );

    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        gpio_pin_mux i_mux (
            .cfg      (cfg[b]),
            .atr_word (atr_word[b]),
            .dbg0     (dbg0_v[b]),
            .dbg1     (dbg1_v[b]),
            .pad_out  (out_v[b]),
            .pad_oe   (oe_v[b])
        );
    end

    assign pad_out_rx = out_v[BANK_RX];
    assign pad_out_tx = out_v[BANK_TX];
    assign pad_oe_rx  = oe_v[BANK_RX];
    assign pad_oe_tx  = oe_v[BANK_TX];

endmodule

// File: rtl/gpio_atr_chk.sv
module gpio_atr_chk
    import gpio_atr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic [BUS_W-1:0]  bus_rdata,
    input logic [BUS_W-1:0]  pad_in_rx,
    input logic [BUS_W-1:0]  pad_out_rx,
    input logic [BUS_W-1:0]  pad_out_tx,
    input logic [BUS_W-1:0]  pad_oe_rx,
    input logic [BUS_W-1:0]  pad_oe_tx
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (pad_oe_rx == '0 && pad_oe_tx == '0 &&
                        pad_out_rx == '0 && pad_out_tx == '0));

    // R4
    oe_follows_dir_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr[4:1] == 4'h1) |=> (pad_oe_rx == $past(bus_wdata)));

    // R2
    cfg_readback_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_addr[4] && bus_addr[2:1] != 2'b00)
        |=> ((bus_addr[4:1] == $past(bus_addr[4:1])) -> bus_rdata == $past(bus_wdata)));

    // R3
    input_sync_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[4:1] == 4'h0) |-> (bus_rdata == $past(pad_in_rx, 2)));

endmodule

bind gpio_atr_ctrl gpio_atr_chk i_chk (.*);

// File: tb/test_gpio_atr_ctrl.sv
module test_gpio_atr_ctrl;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr;
    logic [4:0]  bus_addr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic        tx_active, rx_active;
    logic [15:0] dbg0_rx, dbg1_rx, dbg0_tx, dbg1_tx;
    logic [15:0] pad_in_rx, pad_in_tx;
    logic [15:0] pad_out_rx, pad_out_tx, pad_oe_rx, pad_oe_tx;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_atr_ctrl i_gpio_atr_ctrl (.*);

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [4:0] a, input logic [15:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    function automatic logic [15:0] atr_val(input int st, input int side);
        return 16'hA000 | 16'(st << 4) | 16'(side);
    endfunction

    task automatic t_reset;
        #1;
        check("R1 oe_rx", pad_oe_rx, 16'h0);
        check("R1 oe_tx", pad_oe_tx, 16'h0);
        check("R1 out_rx", pad_out_rx, 16'h0);
        check("R1 out_tx", pad_out_tx, 16'h0);
        rd_check("R1 dir readback", 5'h0A, 16'h0);
    endtask

    task automatic t_readback;
        wr(5'h04, 16'hA5A5);
        rd_check("R2 rx sel", 5'h04, 16'hA5A5);
        wr(5'h0E, 16'h3C3C);
        rd_check("R2 tx dbg", 5'h0E, 16'h3C3C);
        rd_check("R2 rx sel kept", 5'h04, 16'hA5A5);
        wr(5'h04, 16'h0);
        wr(5'h0E, 16'h0);
    endtask

    task automatic t_sync;
        wr(5'h00, 16'hFFFF);
        bus_addr = 5'h00;
        @(negedge clk);
        pad_in_rx = 16'h1234;
        @(negedge clk);
        check("R3 one edge", bus_rdata, 16'h0000);
        @(negedge clk);
        check("R3 two edges", bus_rdata, 16'h1234);
        pad_in_tx = 16'hBEEF;
        @(negedge clk); @(negedge clk);
        rd_check("R3 tx bank", 5'h08, 16'hBEEF);
    endtask

    task automatic t_software;
        wr(5'h00, 16'h5A5A);
        wr(5'h02, 16'hFFFF);
        #1;
        check("R4 oe", pad_oe_rx, 16'hFFFF);
        check("R5 sw out", pad_out_rx, 16'h5A5A);
        wr(5'h02, 16'h00FF);
        #1;
        check("R4 oe partial", pad_oe_rx, 16'h00FF);
        check("R9 masked out", pad_out_rx, 16'h005A);
    endtask

    task automatic t_atr;
        for (int s = 0; s < 4; s++)
            for (int d = 0; d < 2; d++)
                wr(5'(16 + 4*s + 2*d), atr_val(s, d));
        wr(5'h02, 16'hFFFF); wr(5'h04, 16'hFFFF);
        wr(5'h0A, 16'hFFFF); wr(5'h0C, 16'hFFFF);
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            tx_active = s[1]; rx_active = s[0];
            #1;
            check("R6 R7 rx side", pad_out_rx, atr_val(s, 0));
            check("R6 R7 tx side", pad_out_tx, atr_val(s, 1));
        end
        wr(5'h04, 16'h0F0F);
        #1;
        check("R5 R6 mixed", pad_out_rx, (atr_val(3, 0) & 16'h0F0F) | (16'h5A5A & 16'hF0F0));
    endtask

    task automatic t_debug;
        dbg0_rx = 16'h1357; dbg1_rx = 16'hECA8;
        dbg0_tx = 16'h2468; dbg1_tx = 16'hDB97;
        wr(5'h06, 16'hFFFF); wr(5'h04, 16'h00FF);
        wr(5'h0E, 16'hFFFF); wr(5'h0C, 16'h0000);
        #1;
        check("R8 rx mix", pad_out_rx, (16'hECA8 & 16'h00FF) | (16'h1357 & 16'hFF00));
        check("R8 tx bus0", pad_out_tx, 16'h2468);
        wr(5'h0C, 16'hFFFF);
        #1;
        check("R8 tx bus1", pad_out_tx, 16'hDB97);
    endtask

    task automatic t_odd;
        wr(5'h05, 16'h1111);
        rd_check("R10 odd write", 5'h04, 16'h1111);
        rd_check("R10 odd read", 5'h05, 16'h1111);
    endtask

    initial begin
        rst = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        tx_active = 1'b0; rx_active = 1'b0;
        dbg0_rx = '0; dbg1_rx = '0; dbg0_tx = '0; dbg1_tx = '0;
        pad_in_rx = '0; pad_in_tx = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_readback;
        t_sync;
        t_software;
        t_atr;
        t_debug;
        t_odd;
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule